// File: doc/BRIEF.md
# Self-Clearing Indirect Register Port

This block gives a host access to a small bank of internal byte registers through a single bus location. The host writes a register number to that location. The next access to the same location reaches the numbered register instead. After that access the port falls back on its own to the state where it waits for a number. Every indirect access therefore costs two bus cycles: a number write, then a data read or write.

If software has lost track of the port's state, it can read the location repeatedly. The first read either consumes the pending indirect access or already returns zero, and every read after that returns zero.

The slave is longword-aligned. Only byte lane 1 (bits 15:8) carries data. The other lanes are ignored on writes and read back as zero.

Top module: `ptr_regport`

## Requirements
- R1: After synchronous active-high reset, the port waits for a register number and every internal register holds zero.
- R2: A read while the port waits for a number returns zero and leaves the port waiting.
- R3: A write while the port waits for a number, with byte enable bit 1 set, stores wdata[8+IDXW-1:8] as the register number and arms the port.
- R4: An armed write with byte enable bit 1 set stores wdata[15:8] into the numbered register.
- R5: An armed read returns the numbered register on rdata[15:8]. Bits 31:16 and 7:0 of rdata are always zero.
- R6: Exactly one access while armed, read or write, returns the port to waiting for a number.
- R7: Number bits at or above IDXW are ignored, so with 16 registers the number 0x13 selects register 3.
- R8: Register 0 always reads zero, and writes to it are dropped.
- R9: A write with byte enable bit 1 clear has no effect: it changes neither the port state, the stored number, nor any register.
- R10: rdata is zero whenever cs is low or wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | One-cycle access strobe to the port location |
| wr | input | 1 | 1 = write, 0 = read |
| be | input | 4 | Byte enables; only bit 1 is used |
| wdata | input | 32 | Write data; lane 1 is bits 15:8 |
| rdata | output | 32 | Read data, valid while cs is high and wr is low |

## Verification
The bench builds the block with its default of 16 registers, so the number field is 4 bits wide. With that setting, writing 0x13 reaches register 3, which shows the upper bits are discarded. The bench also writes and reads back every register in the bank. The write data carries filler on the unused lanes, which shows those lanes never leak into storage or into the read data.

// File: rtl/ptr_regport.sv
module ptr_regport #(
  parameter int NREG = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cs,
  input  logic        wr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int IDXW = $clog2(NREG);

  logic                    armed;
  logic [IDXW-1:0]         idx;
  logic [NREG-1:0][7:0]    regs;

  wire       lane_ok = be[1];
  wire       take    = cs && (!wr || lane_ok);
  wire [7:0] wbyte   = wdata[15:8];

  initial begin
    size_chk: assert (NREG >= 2 && NREG == (1 << IDXW))
      else $error("NREG must be a power of two");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      idx   <= '0;
    end else if (take) begin
      if (armed) begin
        armed <= 1'b0;
        idx   <= '0;
      end else if (wr) begin
        armed <= 1'b1;
        idx   <= wdata[8 +: IDXW];
      end
    end
  end

  assign regs[0] = 8'h00;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= 8'h00;
      else if (cs && wr && lane_ok && armed && idx == IDXW'(i))
        q <= wbyte;
    end
    assign regs[i] = q;
  end

  assign rdata = (cs && !wr && armed) ? {16'h0000, regs[idx], 8'h00} : 32'h0;

  // R6
  armed_clears_chk: assert property (@(posedge clk) disable iff (rst)
    cs && armed && (!wr || lane_ok) |=> !armed);

  // R2
  idle_read_stays_chk: assert property (@(posedge clk) disable iff (rst)
    cs && !wr && !armed |=> !armed);

  // R3
  index_load_chk: assert property (@(posedge clk) disable iff (rst)
    cs && wr && lane_ok && !armed |=> armed && idx == $past(wdata[8 +: IDXW]));

  // R4
  data_store_chk: assert property (@(posedge clk) disable iff (rst)
    cs && wr && lane_ok && armed && idx != '0 |=> regs[$past(idx)] == $past(wdata[15:8]));

  // R9
  masked_write_chk: assert property (@(posedge clk) disable iff (rst)
    cs && wr && !lane_ok |=> $stable(armed) && $stable(idx) && $stable(regs));

  // R5
  lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdata[31:16] == 16'h0 && rdata[7:0] == 8'h0);
endmodule

// File: tb/ptr_regport_test.sv
module ptr_regport_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cs;
  logic        wr;
  logic [3:0]  be;
  logic [31:0] wdata;
  logic [31:0] rdata;
  int errors = 0;
  int checks = 0;

  ptr_regport #(.NREG(16)) uut (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .be(be), .wdata(wdata), .rdata(rdata)
  );

  always #4 clk = ~clk;

  // vector: {wr, be[3:0], lane1 byte, expected read byte, check}
  localparam int NV = 20;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 4'hF, 8'h05, 8'h00, 1'b0},  // R3 number 5
    {1'b1, 4'hF, 8'hA5, 8'h00, 1'b0},  // R4 store A5
    {1'b0, 4'hF, 8'h00, 8'h00, 1'b1},  // R2 idle read zero
    {1'b1, 4'hF, 8'h05, 8'h00, 1'b0},
    {1'b0, 4'hF, 8'h00, 8'hA5, 1'b1},  // R5 read back
    {1'b0, 4'hF, 8'h00, 8'h00, 1'b1},  // R6 back to waiting
    {1'b1, 4'hF, 8'h13, 8'h00, 1'b0},  // R7 upper bits dropped
    {1'b1, 4'hF, 8'h3C, 8'h00, 1'b0},
    {1'b1, 4'hF, 8'h03, 8'h00, 1'b0},
    {1'b0, 4'hF, 8'h00, 8'h3C, 1'b1},  // R7 register 3 holds 3C
    {1'b1, 4'hF, 8'h00, 8'h00, 1'b0},  // R8 number 0
    {1'b1, 4'hF, 8'hFF, 8'h00, 1'b0},
    {1'b1, 4'hF, 8'h00, 8'h00, 1'b0},
    {1'b0, 4'hF, 8'h00, 8'h00, 1'b1},  // R8 reads zero
    {1'b1, 4'hD, 8'h05, 8'h00, 1'b0},  // R9 masked number write
    {1'b0, 4'hF, 8'h00, 8'h00, 1'b1},  // R9 still waiting
    {1'b1, 4'h2, 8'h05, 8'h00, 1'b0},
    {1'b1, 4'hD, 8'h77, 8'h00, 1'b0},  // R9 masked data write
    {1'b0, 4'hF, 8'h00, 8'hA5, 1'b1},  // R9 still armed, data intact
    {1'b0, 4'hF, 8'h00, 8'h00, 1'b1}   // R6
  };

  task automatic access(input logic w, input logic [3:0] b, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = w; be = b; wdata = {8'h5A, 8'hC3, d, 8'h3C};
  endtask

  task automatic idle();
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; be = 4'h0; wdata = 32'h0;
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    #2;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; cs = 1'b0; wr = 1'b0; be = 4'h0; wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    access(1'b0, 4'hF, 8'h00); check("R1", 32'h0);

    for (int n = 0; n < NV; n++) begin
      access(VEC[n][21], VEC[n][20:17], VEC[n][16:9]);
      if (VEC[n][0]) check($sformatf("R5/vec%0d", n), {16'h0, VEC[n][8:1], 8'h00});
    end

    for (int r = 1; r < 16; r++) begin
      access(1'b1, 4'h2, 8'(r));
      access(1'b1, 4'h2, 8'(r * 17 + 1));
    end
    for (int r = 1; r < 16; r++) begin
      access(1'b1, 4'h2, 8'(r));
      access(1'b0, 4'h0, 8'h00);
      check("R4", {16'h0, 8'(r * 17 + 1), 8'h00});
    end

    access(1'b1, 4'h2, 8'h07);
    idle(); check("R10", 32'h0);
    access(1'b1, 4'h2, 8'h07); check("R10", 32'h0);
    access(1'b0, 4'h2, 8'h00); check("R6", 32'h0);

    access(1'b1, 4'h2, 8'h07);
    @(negedge clk); rst = 1'b1; cs = 1'b0;
    @(negedge clk); rst = 1'b0;
    access(1'b0, 4'h2, 8'h00); check("R1", 32'h0);
    access(1'b1, 4'h2, 8'h07);
    access(1'b0, 4'h2, 8'h00); check("R1", 32'h0);
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule